// File: doc/BRIEF.md
# Quad DAC serial register interface

This block is the digital control core of a four-channel, double-buffered converter. A host writes it over a three-wire serial link (active-low select, serial clock, serial data). Each frame carries a two-bit channel address followed by a data word of `DATA_W` bits (16 or 14), most significant bit first. When the select line returns high, the most recent address-plus-data bits are decoded, and the data goes into the input register of the addressed channel.

A level-sensitive, active-low load strobe copies all four input registers into the four output registers that drive the converter codes. While the strobe is high, the outputs hold. Held low, the block behaves as single-buffered. An asynchronous active-low reset forces every input and output register to zero or to half scale, chosen by a preset pin. A serial data output repeats the input stream a fixed number of clocks later, so several devices can share one chain.

All serial pins are brought into one system clock domain through two-flop synchronisers. Edges of the serial clock and of the select line are then detected in that domain.

Top module: `quad_dac_ctrl`

## Requirements
- R1: A frame is shifted in MSB first as A1, A0, then data bit DATA_W-1 down to bit 0, one bit per serial-clock rising edge. On the select rising edge the data is stored in the addressed input register.
- R2: Address A1A0 = 00 selects channel 0 (output bits [DATA_W-1:0]), 01 selects channel 1, 10 selects channel 2 and 11 selects channel 3 (channel i occupies `dac_q[i*DATA_W +: DATA_W]`). The other three input registers keep their values.
- R3: Only the last DATA_W+2 bits shifted before the select rising edge are decoded. Any bits sent earlier in the same select-low period have no effect.
- R4: While `cs_n` is high, serial-clock edges leave the shift register unchanged. A later select low/high cycle with no clocks re-decodes the unchanged contents.
- R5: While `ldac_n` is high the output registers hold. While it is low, all four output registers take the values of their input registers.
- R6: While `rs_n` is low, and after it is released, every input and output register holds the reset code. The reset code is 0 when `preset_mid` = 0 and has only bit DATA_W-1 set when `preset_mid` = 1. The codes stay until a serial load changes them.
- R7: A bit sampled from `sdi` on serial-clock rising edge k is on `sdo` at rising edge k+DATA_W+3. `sdo` changes only after falling edges.
- R8: With `ldac_n` held low, a completed frame reaches its output register without any strobe pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rs_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| preset_mid | input | 1 | Reset code select: 0 gives zero, 1 gives half scale |
| cs_n | input | 1 | Active-low serial select; its rising edge loads an input register |
| sclk | input | 1 | Serial clock; data is sampled on its rising edge |
| sdi | input | 1 | Serial data in |
| ldac_n | input | 1 | Active-low level-sensitive load strobe for the output registers |
| sdo | output | 1 | Serial data out for daisy-chaining |
| dac_q | output | 4*DATA_W | Four output codes; channel i at bits [i*DATA_W +: DATA_W] |

## Verification
Each channel is written with a distinct code. This shows that the address reaches the right register and that the other channels are untouched. Frames with a padding prefix, including a prefix that looks like a valid address and data, show that only the final DATA_W+2 bits count. Clock pulses sent while deselected, followed by an empty select cycle, show that the shift register is frozen. A long continuous stream compares `sdo` against the input delayed by exactly DATA_W+3 edges, and the stream's final bits are then decoded as a frame. Strobe-high, strobe-pulsed and strobe-tied-low runs, plus resets with both preset settings, separate hold from copy and the zero code from the half-scale code.

// File: rtl/dacc_pkg.sv
package dacc_pkg;
  // Address field width of a serial frame; decode order depends on it.
  localparam int DACC_ADDR_W = 2;
  localparam int DACC_NCH    = 1 << DACC_ADDR_W;
  // Synchroniser depth for the serial pins.
  localparam int DACC_SYNC_STAGES = 2;
  // Order of synchronised pins inside the pin vector.
  localparam int PIN_CS   = 0;
  localparam int PIN_SCLK = 1;
  localparam int PIN_SDI  = 2;
  localparam int PIN_LDAC = 3;
  localparam int PIN_CNT  = 4;
endpackage

// File: rtl/dacc_rst_sync.sv
module dacc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n = chain_q[STAGES-1];
endmodule

// File: rtl/dacc_sync.sv
module dacc_sync #(
  parameter int          WIDTH   = 4,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] st_q;
    logic [STAGES-1:0] st_d;

    always_comb begin
      st_d = {st_q[STAGES-2:0], din[b]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= {STAGES{RST_VAL[b]}};
      else        st_q <= st_d;
    end

    assign dout[b] = st_q[STAGES-1];
  end
endmodule

// File: rtl/dacc_serial.sv
module dacc_serial
  import dacc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cs_s,
  input  logic                   sclk_s,
  input  logic                   sdi_s,
  output logic                   load_pulse,
  output logic [DACC_ADDR_W-1:0] load_addr,
  output logic [DATA_W-1:0]      load_data,
  output logic                   sdo
);
  localparam int FRAME_W = DATA_W + DACC_ADDR_W;
  // One stage beyond the frame feeds the chain output.
  localparam int SR_W    = FRAME_W + 1;

  logic            sclk_d_q, cs_d_q;
  logic [SR_W-1:0] sr_q, sr_d;
  logic            sdo_q, sdo_d;
  logic            sclk_rise, sclk_fall, cs_rise, shift_en;

  always_comb begin
    sclk_rise = sclk_s & ~sclk_d_q;
    sclk_fall = ~sclk_s & sclk_d_q;
    cs_rise   = cs_s & ~cs_d_q;
    shift_en  = sclk_rise & ~cs_s;
    sr_d      = sr_q;
    if (shift_en) sr_d = {sr_q[SR_W-2:0], sdi_s};
    sdo_d     = sdo_q;
    if (sclk_fall) sdo_d = sr_q[SR_W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d_q <= 1'b0;
      cs_d_q   <= 1'b1;
      sr_q     <= '0;
      sdo_q    <= 1'b0;
    end else begin
      sclk_d_q <= sclk_s;
      cs_d_q   <= cs_s;
      sr_q     <= sr_d;
      sdo_q    <= sdo_d;
    end
  end

  assign load_pulse = cs_rise;
  assign load_addr  = sr_q[FRAME_W-1 -: DACC_ADDR_W];
  assign load_data  = sr_q[DATA_W-1:0];
  assign sdo        = sdo_q;
endmodule

// File: rtl/dacc_regbank.sv
module dacc_regbank
  import dacc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NCH    = DACC_NCH
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   preset_mid,
  input  logic                   load,
  input  logic [DACC_ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0]      data,
  input  logic                   ldac_s,
  output logic [NCH*DATA_W-1:0]  inr_q,
  output logic [NCH*DATA_W-1:0]  dac_q
);
  logic [DATA_W-1:0] rst_code;

  always_comb begin
    rst_code = preset_mid ? {1'b1, {(DATA_W-1){1'b0}}} : '0;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic              we;
    logic [DATA_W-1:0] in_q, in_d, out_q, out_d;

    always_comb begin
      we    = load && (addr == DACC_ADDR_W'(i));
      in_d  = we ? data : in_q;
      out_d = ldac_s ? out_q : in_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        in_q  <= rst_code;
        out_q <= rst_code;
      end else begin
        in_q  <= in_d;
        out_q <= out_d;
      end
    end

    assign inr_q[i*DATA_W +: DATA_W] = in_q;
    assign dac_q[i*DATA_W +: DATA_W] = out_q;
  end
endmodule

// File: rtl/quad_dac_ctrl.sv
module quad_dac_ctrl
  import dacc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                         clk,
  input  logic                         rs_n,
  input  logic                         preset_mid,
  input  logic                         cs_n,
  input  logic                         sclk,
  input  logic                         sdi,
  input  logic                         ldac_n,
  output logic                         sdo,
  output logic [DACC_NCH*DATA_W-1:0]   dac_q
);
  localparam int NCH = DACC_NCH;
  localparam logic [PIN_CNT-1:0] PIN_IDLE = PIN_CNT'((1 << PIN_CS) | (1 << PIN_LDAC));

  logic                   rst_n_int;
  logic [PIN_CNT-1:0]     pins_raw, pins_s;
  logic                   cs_s, sclk_s, sdi_s, ldac_s;
  logic                   load_pulse;
  logic [DACC_ADDR_W-1:0] load_addr;
  logic [DATA_W-1:0]      load_data;
  logic [NCH*DATA_W-1:0]  inr_q;

  dacc_rst_sync #(.STAGES(DACC_SYNC_STAGES)) u_rst (
    .clk(clk), .arst_n(rs_n), .rst_n(rst_n_int)
  );

  always_comb begin
    pins_raw           = '0;
    pins_raw[PIN_CS]   = cs_n;
    pins_raw[PIN_SCLK] = sclk;
    pins_raw[PIN_SDI]  = sdi;
    pins_raw[PIN_LDAC] = ldac_n;
  end

  dacc_sync #(.WIDTH(PIN_CNT), .STAGES(DACC_SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n_int), .din(pins_raw), .dout(pins_s)
  );

  assign cs_s   = pins_s[PIN_CS];
  assign sclk_s = pins_s[PIN_SCLK];
  assign sdi_s  = pins_s[PIN_SDI];
  assign ldac_s = pins_s[PIN_LDAC];

  dacc_serial #(.DATA_W(DATA_W)) u_ser (
    .clk(clk), .rst_n(rst_n_int), .cs_s(cs_s), .sclk_s(sclk_s), .sdi_s(sdi_s),
    .load_pulse(load_pulse), .load_addr(load_addr), .load_data(load_data), .sdo(sdo)
  );

  dacc_regbank #(.DATA_W(DATA_W), .NCH(NCH)) u_bank (
    .clk(clk), .rst_n(rst_n_int), .preset_mid(preset_mid), .load(load_pulse),
    .addr(load_addr), .data(load_data), .ldac_s(ldac_s), .inr_q(inr_q), .dac_q(dac_q)
  );
endmodule

// File: rtl/dacc_checker.sv
module dacc_checker #(
  parameter int DATA_W = 16,
  parameter int NCH    = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cs_s,
  input logic                    ldac_s,
  input logic                    load_pulse,
  input logic [DATA_W+1:0]       frame,
  input logic [NCH*DATA_W-1:0]   inr_q,
  input logic [NCH*DATA_W-1:0]   dac_q
);
  logic [NCH*DATA_W-1:0] inr_prev_q;
  logic [NCH-1:0]        chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inr_prev_q <= '0;
    else        inr_prev_q <= inr_q;
  end

  always_comb begin
    for (int i = 0; i < NCH; i++)
      chg[i] = inr_q[i*DATA_W +: DATA_W] != inr_prev_q[i*DATA_W +: DATA_W];
  end

  // R4: deselected serial clocks do not move the frame
  a_r4_frozen_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s && $past(cs_s)) |-> $stable(frame));

  // R5: outputs hold while strobe is high
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ldac_s |=> $stable(dac_q));

  // R5: outputs copy input registers while strobe is low
  a_r5_copy: assert property (@(posedge clk) disable iff (!rst_n)
    !ldac_s |=> (dac_q == $past(inr_q)));

  // R2: input registers change only on a load
  a_r2_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
    !load_pulse |=> $stable(inr_q));

  // R2: a load touches at most one channel
  a_r2_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
    load_pulse |=> ($countones(chg) <= 1));
endmodule

bind quad_dac_ctrl dacc_checker #(.DATA_W(DATA_W), .NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n_int), .cs_s(cs_s), .ldac_s(ldac_s),
  .load_pulse(load_pulse), .frame({load_addr, load_data}),
  .inr_q(inr_q), .dac_q(dac_q)
);

// File: tb/tb_quad_dac_ctrl.sv
module tb_quad_dac_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int W    = 16;
  localparam int FW   = W + 2;
  localparam int HALF = 6;
  localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};

  logic clk = 1'b0;
  logic rs_n, preset_mid, cs_n, sclk, sdi, ldac_n;
  logic sdo;
  logic [4*W-1:0] dac_q;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [W-1:0] exp_in [4];
  logic [W-1:0] exp_out[4];

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_dac_ctrl #(.DATA_W(W)) dut (
    .clk(clk), .rs_n(rs_n), .preset_mid(preset_mid), .cs_n(cs_n), .sclk(sclk),
    .sdi(sdi), .ldac_n(ldac_n), .sdo(sdo), .dac_q(dac_q)
  );

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_val(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_outs(input string req);
    for (int i = 0; i < 4; i++) check_val(req, dac_q[i*W +: W], exp_out[i]);
  endtask

  task automatic send_frame(input logic [63:0] bits, input int len);
    cs_n = 1'b0;
    wait_cyc(HALF);
    for (int k = len - 1; k >= 0; k--) begin
      sdi = bits[k]; sclk = 1'b0; wait_cyc(HALF);
      sclk = 1'b1; wait_cyc(HALF);
    end
    sclk = 1'b0; wait_cyc(HALF);
    cs_n = 1'b1; wait_cyc(HALF);
  endtask

  task automatic write_ch(input logic [1:0] ch, input logic [W-1:0] val);
    send_frame({46'd0, ch, val}, FW);
    exp_in[ch] = val;
  endtask

  task automatic strobe();
    ldac_n = 1'b0; wait_cyc(HALF);
    ldac_n = 1'b1; wait_cyc(HALF);
    for (int i = 0; i < 4; i++) exp_out[i] = exp_in[i];
  endtask

  task automatic do_reset(input logic mid);
    logic [W-1:0] code;
    code = mid ? MID : '0;
    preset_mid = mid;
    rs_n = 1'b0;
    wait_cyc(3);
    for (int i = 0; i < 4; i++) begin exp_in[i] = code; exp_out[i] = code; end
    check_outs("R6 during reset");
    rs_n = 1'b1;
    wait_cyc(8);
    check_outs("R6 after release");
    strobe();
    check_outs("R6 input registers preset");
  endtask

  task automatic t_channels();
    write_ch(2'd0, 16'h1234);
    write_ch(2'd1, 16'hABCD);
    write_ch(2'd2, 16'h0F0F);
    write_ch(2'd3, 16'hFFFE);
    check_outs("R5 hold with strobe high");
    strobe();
    check_outs("R1 R2 all channels loaded");
    write_ch(2'd2, 16'h5A5A);
    strobe();
    check_outs("R2 only channel 2 changed");
  endtask

  task automatic t_padding();
    // valid-looking junk prefix, then the real frame for channel 1
    send_frame({22'd0, 6'b111111, 2'b01, 16'hC0DE} | (64'h3 << 18), 24);
    exp_in[1] = 16'hC0DE;
    strobe();
    check_outs("R3 24-bit padded frame");
    send_frame({2'b11, 16'h7777, 2'b00, 16'h0001} | (64'h1 << 39), 40);
    exp_in[0] = 16'h0001;
    strobe();
    check_outs("R3 40-bit padded frame");
  endtask

  task automatic t_deselected();
    write_ch(2'd1, 16'h2468);
    strobe();
    for (int k = 0; k < 10; k++) begin
      sdi = k[0]; sclk = 1'b1; wait_cyc(HALF);
      sclk = 1'b0; wait_cyc(HALF);
    end
    cs_n = 1'b0; wait_cyc(HALF);
    cs_n = 1'b1; wait_cyc(HALF);
    strobe();
    check_outs("R4 clocks with cs high ignored");
  endtask

  task automatic t_sdo();
    localparam int L = 2 * (W + 3) + 4;
    logic [63:0] pat;
    logic b [L+1];
    logic [1:0] a;
    logic [W-1:0] d;
    pat = 64'hC3A5_9F01_7E2D_4B86;
    for (int k = 1; k <= L; k++) b[k] = pat[k % 64];
    cs_n = 1'b0; wait_cyc(HALF);
    for (int k = 1; k <= L; k++) begin
      sdi = b[k]; sclk = 1'b0; wait_cyc(HALF);
      if (k > W + 3) begin
        checks++;
        if (sdo !== b[k-W-3]) begin
          errors++;
          $display("FAIL R7 sdo at edge %0d actual=%b expected=%b", k, sdo, b[k-W-3]);
        end
      end
      sclk = 1'b1; wait_cyc(HALF);
    end
    sclk = 1'b0; wait_cyc(HALF);
    cs_n = 1'b1; wait_cyc(HALF);
    a = {b[L-FW+1], b[L-FW+2]};
    for (int j = 0; j < W; j++) d[W-1-j] = b[L-FW+3+j];
    exp_in[a] = d;
    strobe();
    check_outs("R3 R7 stream tail decoded");
  endtask

  task automatic t_single_buffer();
    ldac_n = 1'b0;
    wait_cyc(HALF);
    write_ch(2'd3, 16'h3C3C);
    for (int i = 0; i < 4; i++) exp_out[i] = exp_in[i];
    check_outs("R8 strobe tied low");
    ldac_n = 1'b1;
    wait_cyc(HALF);
  endtask

  initial begin
    rs_n = 1'b0; preset_mid = 1'b0; cs_n = 1'b1; sclk = 1'b0; sdi = 1'b0; ldac_n = 1'b1;
    for (int i = 0; i < 4; i++) begin exp_in[i] = '0; exp_out[i] = '0; end
    wait_cyc(4);
    check_outs("R6 zero code at power-on");
    rs_n = 1'b1;
    wait_cyc(8);
    check_outs("R6 zero code after release");
    t_channels();
    t_padding();
    t_deselected();
    t_sdo();
    t_single_buffer();
    do_reset(1'b1);
    write_ch(2'd0, 16'h0042);
    strobe();
    check_outs("R1 write after half-scale reset");
    do_reset(1'b0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule